// File: doc/BRIEF.md
# Channelized I/O Device Port with Busy/Done Handshake

This block is the device side of one peripheral on a shared, channel-addressed I/O bus. Every bus operation carries a channel number. The block answers only when that number equals its own channel, which is set by a parameter. When selected, it lets the CPU write or read one of three 16-bit data/control registers, named A, B and C. It also acts on one control signal per operation: start, clear or pulse.

A start marks the device busy. The device mechanism is modelled by a local `op_done` input. When that input arrives, the busy flag drops and the done flag rises. A clear abandons the operation and drops both flags. A pulse produces a one-cycle strobe for an ancillary action and does not touch the handshake. The CPU can query either flag for set or clear, and the result comes back as a skip answer in the same cycle.

The done flag drives an interrupt request. The request is qualified by a global enable and by a mask bit, and the mask bit is taken from a mask broadcast. A bus-wide I/O reset stops the device and drops all interrupt state. The highest channel number is reserved for the CPU, and no device ever answers on it.

Top module: `iodev_port`

## Requirements
- R1: A write (`bus_wr`=1) to register A, B or C (`bus_rsel` 1, 2, 3) with a matching channel stores `bus_wdata` at the next clock edge. A read (`bus_wr`=0) with a matching channel drives that register on `bus_rdata` in the same cycle. `bus_rdata` is zero whenever no read is selected, which includes `bus_rsel`=0.
- R2: An operation whose channel differs from `DEV_CHAN` has no effect, and neither has one on channel 63. Such an operation leaves `bus_sel` low, leaves `bus_skip` low and leaves `bus_rdata` at zero.
- R3: A start signal (`bus_sig`=1) on the device's channel sets busy and clears done at the next edge.
- R4: `op_done` while busy clears busy and sets done at the next edge. `op_done` while not busy changes nothing.
- R5: A clear signal (`bus_sig`=2) clears both busy and done at the next edge, whether or not an operation is running.
- R6: A pulse signal (`bus_sig`=3) raises `pulse_strobe` for exactly the one cycle after the edge and does not change busy or done.
- R7: `irq` is high exactly when done is set, `int_en` is high and the device's mask bit is clear.
- R8: When `mask_wr` is high, the mask bit is loaded at the next edge from bit `MASK_BIT` of `mask_data`. All other bits of `mask_data` are ignored.
- R9: A register write and a signal in the same operation both take effect at one edge. A start has priority over an `op_done` arriving in the same cycle, so the result is busy set and done clear.
- R10: A status query (`bus_test`=1) drives `bus_skip` in the same cycle. The condition is selected by `bus_tsel`: 0 means busy set, 1 means busy clear, 2 means done set and 3 means done clear.
- R11: `io_rst` clears busy, done, the mask bit and the strobe at the next edge. Registers A, B and C keep their contents.
- R12: `rst` clears every register, both flags, the mask bit and the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | A bus operation is present this cycle |
| bus_chan | input | 6 | Channel number of the operation |
| bus_rsel | input | 2 | Register select: 0 none, 1 A, 2 B, 3 C |
| bus_wr | input | 1 | 1 means CPU to device, 0 means device to CPU |
| bus_wdata | input | 16 | Write data |
| bus_sig | input | 2 | Signal: 0 none, 1 start, 2 clear, 3 pulse |
| bus_test | input | 1 | Status query present |
| bus_tsel | input | 2 | Query condition select |
| bus_rdata | output | 16 | Read data, zero when not selected |
| bus_sel | output | 1 | Operation addresses this device |
| bus_skip | output | 1 | Query result |
| op_done | input | 1 | Device mechanism finished |
| int_en | input | 1 | Global interrupt enable |
| mask_wr | input | 1 | Mask broadcast strobe |
| mask_data | input | 16 | Mask broadcast word |
| io_rst | input | 1 | Bus-wide I/O reset |
| busy | output | 1 | Busy flag |
| done | output | 1 | Done flag |
| irq | output | 1 | Interrupt request |
| pulse_strobe | output | 1 | One-cycle ancillary strobe |

## Verification
The hardest situations to reach are the collisions. One is a start and a completion in the same cycle. Another is a clear landing while an operation is still running. A third is a mask change that must withdraw a request which is already asserted. The vector table walks the flags through busy, done and clear, with queries placed between the steps. Directed sequences then push `op_done` into the same cycle as a start, and toggle the mask bit and `int_en` while done is held. The mask toggling uses words in which only the assigned bit, or every bit except it, is set. Last, an I/O reset is issued with the mask set, and register A is read back to show that it survived.

// File: rtl/iodev_pkg.sv
package iodev_pkg;

    localparam int DATA_W = 16;
    localparam int CHAN_W = 6;

    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_A    = 2'd1,
        RSEL_B    = 2'd2,
        RSEL_C    = 2'd3
    } rsel_e;

    typedef enum logic [1:0] {
        SIG_NONE  = 2'd0,
        SIG_START = 2'd1,
        SIG_CLEAR = 2'd2,
        SIG_PULSE = 2'd3
    } sig_e;

    typedef enum logic [1:0] {
        TST_BUSY_SET = 2'd0,
        TST_BUSY_CLR = 2'd1,
        TST_DONE_SET = 2'd2,
        TST_DONE_CLR = 2'd3
    } tst_e;

    // Decoded bus operation, valid only for this device.
    typedef struct packed {
        logic  hit;
        logic  do_wr;
        logic  do_rd;
        rsel_e rsel;
        logic  start;
        logic  clear;
        logic  pulse;
        logic  test;
        tst_e  tsel;
    } cmd_t;

    function automatic logic test_eval(tst_e t, logic b, logic d);
        logic r;
        case (t)
            TST_BUSY_SET: r = b;
            TST_BUSY_CLR: r = !b;
            TST_DONE_SET: r = d;
            default:      r = !d;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/iodev_decode.sv
module iodev_decode
    import iodev_pkg::*;
#(
    parameter int               CW       = 6,
    parameter logic [CW-1:0]    DEV_CHAN = 12
) (
    input  logic          valid,
    input  logic [CW-1:0] chan,
    input  logic [1:0]    rsel,
    input  logic          wr,
    input  logic [1:0]    sig,
    input  logic          test,
    input  logic [1:0]    tsel,
    output cmd_t          cmd
);
    localparam logic [CW-1:0] CPU_CHAN = {CW{1'b1}};

    logic  hit;
    rsel_e rs;
    sig_e  sg;

    always_comb begin
        hit = valid && (chan == DEV_CHAN) && (chan != CPU_CHAN);
        rs  = rsel_e'(rsel);
        sg  = sig_e'(sig);
        cmd.hit   = hit;
        cmd.rsel  = rs;
        cmd.do_wr = hit && wr && (rs != RSEL_NONE);
        cmd.do_rd = hit && !wr && (rs != RSEL_NONE);
        cmd.start = hit && (sg == SIG_START);
        cmd.clear = hit && (sg == SIG_CLEAR);
        cmd.pulse = hit && (sg == SIG_PULSE);
        cmd.test  = hit && test;
        cmd.tsel  = tst_e'(tsel);
    end
endmodule

// File: rtl/iodev_regfile.sv
module iodev_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 3,
    localparam int IW  = $clog2(NREG + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wdata,
    input  logic          rd_en,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] regs [NREG];

    // Index 0 selects nothing; register g answers to index g+1.
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (wr_en && wr_idx == IW'(g + 1))
                regs[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++)
            if (rd_en && rd_idx == IW'(i + 1))
                rdata = regs[i];
    end
endmodule

// File: rtl/iodev_flags.sv
module iodev_flags #(
    parameter int DW       = 16,
    parameter int MASK_BIT = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          io_rst,
    input  logic          start,
    input  logic          clear,
    input  logic          pulse,
    input  logic          op_done,
    input  logic          mask_wr,
    input  logic [DW-1:0] mask_data,
    input  logic          int_en,
    output logic          busy,
    output logic          done,
    output logic          irq,
    output logic          strobe
);
    logic mask_q;

    always_ff @(posedge clk) begin
        if (rst || io_rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            mask_q <= 1'b0;
            strobe <= 1'b0;
        end else begin
            strobe <= pulse;
            if (mask_wr)
                mask_q <= mask_data[MASK_BIT];
            if (clear) begin
                busy <= 1'b0;
                done <= 1'b0;
            end else if (start) begin
                busy <= 1'b1;
                done <= 1'b0;
            end else if (op_done && busy) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    assign irq = done && int_en && !mask_q;
endmodule

// File: rtl/iodev_port.sv
module iodev_port
    import iodev_pkg::*;
#(
    parameter logic [5:0] DEV_CHAN = 6'd12,
    parameter int         MASK_BIT = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_valid,
    input  logic [5:0]  bus_chan,
    input  logic [1:0]  bus_rsel,
    input  logic        bus_wr,
    input  logic [15:0] bus_wdata,
    input  logic [1:0]  bus_sig,
    input  logic        bus_test,
    input  logic [1:0]  bus_tsel,
    output logic [15:0] bus_rdata,
    output logic        bus_sel,
    output logic        bus_skip,
    input  logic        op_done,
    input  logic        int_en,
    input  logic        mask_wr,
    input  logic [15:0] mask_data,
    input  logic        io_rst,
    output logic        busy,
    output logic        done,
    output logic        irq,
    output logic        pulse_strobe
);
    localparam int NREG = 3;

    cmd_t cmd;

    iodev_decode #(.CW(CHAN_W), .DEV_CHAN(DEV_CHAN)) u_dec (
        .valid (bus_valid),
        .chan  (bus_chan),
        .rsel  (bus_rsel),
        .wr    (bus_wr),
        .sig   (bus_sig),
        .test  (bus_test),
        .tsel  (bus_tsel),
        .cmd   (cmd)
    );

    iodev_regfile #(.DW(DATA_W), .NREG(NREG)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cmd.do_wr),
        .wr_idx (cmd.rsel),
        .wdata  (bus_wdata),
        .rd_en  (cmd.do_rd),
        .rd_idx (cmd.rsel),
        .rdata  (bus_rdata)
    );

    iodev_flags #(.DW(DATA_W), .MASK_BIT(MASK_BIT)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .io_rst    (io_rst),
        .start     (cmd.start),
        .clear     (cmd.clear),
        .pulse     (cmd.pulse),
        .op_done   (op_done),
        .mask_wr   (mask_wr),
        .mask_data (mask_data),
        .int_en    (int_en),
        .busy      (busy),
        .done      (done),
        .irq       (irq),
        .strobe    (pulse_strobe)
    );

    assign bus_sel  = cmd.hit;
    assign bus_skip = cmd.test && test_eval(cmd.tsel, busy, done);
endmodule

// File: rtl/iodev_port_chk.sv
module iodev_port_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_valid,
    input logic [5:0]  bus_chan,
    input logic [1:0]  bus_sig,
    input logic        bus_test,
    input logic        bus_sel,
    input logic        bus_skip,
    input logic        op_done,
    input logic        int_en,
    input logic        io_rst,
    input logic        busy,
    input logic        done,
    input logic        irq,
    input logic        pulse_strobe
);
    a_r2_cpu_chan: assert property (@(posedge clk) disable iff (rst)
        bus_chan == 6'h3F |-> !bus_sel);

    a_r3_start_busy: assert property (@(posedge clk) disable iff (rst)
        bus_valid && bus_sel && bus_sig == 2'd1 && !io_rst |=> busy && !done);

    a_r4_complete: assert property (@(posedge clk) disable iff (rst)
        busy && op_done && !io_rst && !(bus_valid && bus_sel && (bus_sig == 2'd1 || bus_sig == 2'd2))
        |=> done && !busy);

    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
        bus_valid && bus_sel && bus_sig == 2'd2 |=> !busy && !done);

    a_r6_strobe_cause: assert property (@(posedge clk) disable iff (rst)
        pulse_strobe |-> $past(bus_valid && bus_sel && bus_sig == 2'd3 && !io_rst));

    a_r7_irq_needs_done: assert property (@(posedge clk) disable iff (rst)
        irq |-> done && int_en);

    a_r10_skip_selected: assert property (@(posedge clk) disable iff (rst)
        bus_skip |-> bus_valid && bus_sel && bus_test);

    a_r11_iorst: assert property (@(posedge clk) disable iff (rst)
        io_rst |=> !busy && !done && !pulse_strobe);

    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));
endmodule

bind iodev_port iodev_port_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_valid    (bus_valid),
    .bus_chan     (bus_chan),
    .bus_sig      (bus_sig),
    .bus_test     (bus_test),
    .bus_sel      (bus_sel),
    .bus_skip     (bus_skip),
    .op_done      (op_done),
    .int_en       (int_en),
    .io_rst       (io_rst),
    .busy         (busy),
    .done         (done),
    .irq          (irq),
    .pulse_strobe (pulse_strobe)
);

// File: tb/iodev_port_tb.sv
module iodev_port_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_valid;
    logic [5:0]  bus_chan;
    logic [1:0]  bus_rsel;
    logic        bus_wr;
    logic [15:0] bus_wdata;
    logic [1:0]  bus_sig;
    logic        bus_test;
    logic [1:0]  bus_tsel;
    logic [15:0] bus_rdata;
    logic        bus_sel;
    logic        bus_skip;
    logic        op_done;
    logic        int_en;
    logic        mask_wr;
    logic [15:0] mask_data;
    logic        io_rst;
    logic        busy;
    logic        done;
    logic        irq;
    logic        pulse_strobe;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    iodev_port #(.DEV_CHAN(6'd12), .MASK_BIT(3)) u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_chan(bus_chan),
        .bus_rsel(bus_rsel), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_sig(bus_sig), .bus_test(bus_test), .bus_tsel(bus_tsel),
        .bus_rdata(bus_rdata), .bus_sel(bus_sel), .bus_skip(bus_skip),
        .op_done(op_done), .int_en(int_en), .mask_wr(mask_wr),
        .mask_data(mask_data), .io_rst(io_rst), .busy(busy), .done(done),
        .irq(irq), .pulse_strobe(pulse_strobe)
    );

    typedef struct packed {
        logic [5:0]  chan;
        logic [1:0]  rsel;
        logic        wr;
        logic [15:0] data;
        logic [1:0]  sig;
        logic        tst;
        logic [1:0]  tsel;
        logic        opd;
        logic [15:0] exp_rd;
        logic        exp_skip;
        logic        exp_busy;
        logic        exp_done;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        '{6'd12, 2'd1, 1'b1, 16'h1234, 2'd0, 1'b0, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 8'd1},  // R1 write A
        '{6'd12, 2'd1, 1'b0, 16'h0000, 2'd0, 1'b0, 2'd0, 1'b0, 16'h1234, 1'b0, 1'b0, 1'b0, 8'd1},  // R1 read A
        '{6'd13, 2'd2, 1'b1, 16'hBEEF, 2'd0, 1'b0, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 foreign write
        '{6'd12, 2'd2, 1'b0, 16'h0000, 2'd0, 1'b0, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 B untouched
        '{6'd63, 2'd1, 1'b1, 16'hFFFF, 2'd1, 1'b0, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 cpu channel
        '{6'd12, 2'd1, 1'b0, 16'h0000, 2'd0, 1'b0, 2'd0, 1'b0, 16'h1234, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 A kept
        '{6'd12, 2'd3, 1'b1, 16'h00F0, 2'd1, 1'b0, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 8'd9},  // R9 R3 write C + start
        '{6'd12, 2'd3, 1'b0, 16'h0000, 2'd0, 1'b0, 2'd0, 1'b0, 16'h00F0, 1'b0, 1'b1, 1'b0, 8'd9},  // R9 read C
        '{6'd12, 2'd0, 1'b0, 16'h0000, 2'd0, 1'b1, 2'd0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 8'd10}, // R10 busy set
        '{6'd12, 2'd0, 1'b0, 16'h0000, 2'd0, 1'b1, 2'd2, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 8'd10}, // R10 done set no
        '{6'd12, 2'd0, 1'b0, 16'h0000, 2'd0, 1'b0, 2'd0, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b1, 8'd4},  // R4 complete
        '{6'd12, 2'd0, 1'b0, 16'h0000, 2'd0, 1'b1, 2'd2, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 8'd10}, // R10 done set
        '{6'd12, 2'd0, 1'b0, 16'h0000, 2'd0, 1'b1, 2'd1, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 8'd10}, // R10 busy clear
        '{6'd12, 2'd0, 1'b0, 16'h0000, 2'd0, 1'b1, 2'd3, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 8'd10}, // R10 done clear no
        '{6'd63, 2'd0, 1'b0, 16'h0000, 2'd0, 1'b1, 2'd2, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 8'd2},  // R2 query cpu chan
        '{6'd12, 2'd0, 1'b0, 16'h0000, 2'd2, 1'b0, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 8'd5},  // R5 clear done
        '{6'd12, 2'd0, 1'b0, 16'h0000, 2'd0, 1'b0, 2'd0, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 8'd4},  // R4 idle op_done
        '{6'd12, 2'd0, 1'b0, 16'h0000, 2'd1, 1'b0, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 8'd3},  // R3 start
        '{6'd12, 2'd0, 1'b0, 16'h0000, 2'd2, 1'b0, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 8'd5},  // R5 clear busy
        '{6'd12, 2'd0, 1'b0, 16'h0000, 2'd0, 1'b1, 2'd3, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 8'd10}, // R10 done clear
        '{6'd12, 2'd0, 1'b0, 16'h0000, 2'd0, 1'b1, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 8'd10}  // R10 busy set no
    };

    task automatic chk(input int req, input logic [15:0] act, input logic [15:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        bus_valid = 1'b0; bus_chan = 6'd0; bus_rsel = 2'd0; bus_wr = 1'b0;
        bus_wdata = 16'h0; bus_sig = 2'd0; bus_test = 1'b0; bus_tsel = 2'd0;
        op_done = 1'b0; mask_wr = 1'b0; mask_data = 16'h0; io_rst = 1'b0;
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic op(input logic [5:0] ch, input logic [1:0] rs, input logic w,
                      input logic [15:0] d, input logic [1:0] sg);
        bus_valid = 1'b1; bus_chan = ch; bus_rsel = rs; bus_wr = w;
        bus_wdata = d; bus_sig = sg;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle();
        int_en = 1'b1;
        rst = 1'b1;
        repeat (3) cyc();
        rst = 1'b0;
        // R12 reset state
        chk(12, {12'h0, busy, done, irq, pulse_strobe}, 16'h0, "flags after reset");
        op(6'd12, 2'd1, 1'b0, 16'h0, 2'd0); #1;
        chk(12, bus_rdata, 16'h0, "A after reset");
        idle();
        cyc();

        for (int i = 0; i < NV; i++) begin
            op(TBL[i].chan, TBL[i].rsel, TBL[i].wr, TBL[i].data, TBL[i].sig);
            bus_test = TBL[i].tst; bus_tsel = TBL[i].tsel; op_done = TBL[i].opd;
            #1;
            chk(TBL[i].req, bus_rdata, TBL[i].exp_rd, $sformatf("vec %0d rdata", i));
            chk(TBL[i].req, {15'h0, bus_skip}, {15'h0, TBL[i].exp_skip}, $sformatf("vec %0d skip", i));
            chk(2, {15'h0, bus_sel}, {15'h0, TBL[i].chan == 6'd12}, $sformatf("vec %0d sel", i));
            cyc();
            idle();
            chk(TBL[i].req, {14'h0, busy, done}, {14'h0, TBL[i].exp_busy, TBL[i].exp_done},
                $sformatf("vec %0d busy/done", i));
        end

        // R6 pulse gives a single-cycle strobe, flags untouched
        op(6'd12, 2'd0, 1'b0, 16'h0, 2'd3); cyc(); idle();
        chk(6, {13'h0, pulse_strobe, busy, done}, 16'h4, "strobe after pulse");
        cyc();
        chk(6, {15'h0, pulse_strobe}, 16'h0, "strobe one cycle only");

        // R9 start wins over simultaneous op_done
        op(6'd12, 2'd0, 1'b0, 16'h0, 2'd1); cyc(); idle();
        op(6'd12, 2'd0, 1'b0, 16'h0, 2'd1); op_done = 1'b1; cyc(); idle();
        chk(9, {14'h0, busy, done}, 16'h2, "start beats op_done");

        // R7 interrupt follows done with enable and mask
        op_done = 1'b1; cyc(); idle();
        chk(7, {15'h0, irq}, 16'h1, "irq with done enabled");
        int_en = 1'b0; #1;
        chk(7, {15'h0, irq}, 16'h0, "irq gated by int_en");
        int_en = 1'b1;
        // R8 mask bit 3 captured, other bits ignored
        mask_wr = 1'b1; mask_data = 16'h0008; cyc(); idle();
        chk(8, {15'h0, irq}, 16'h0, "irq masked by bit 3");
        mask_wr = 1'b1; mask_data = 16'hFFF7; cyc(); idle();
        chk(8, {15'h0, irq}, 16'h1, "other mask bits ignored");

        // R11 I/O reset clears flags and mask, keeps registers
        op(6'd12, 2'd1, 1'b1, 16'h5A5A, 2'd0); cyc(); idle();
        mask_wr = 1'b1; mask_data = 16'h0008; cyc(); idle();
        io_rst = 1'b1; cyc(); idle();
        chk(11, {13'h0, busy, done, irq}, 16'h0, "flags after io_rst");
        op(6'd12, 2'd1, 1'b0, 16'h0, 2'd0); #1;
        chk(11, bus_rdata, 16'h5A5A, "A kept across io_rst");
        idle();
        op(6'd12, 2'd0, 1'b0, 16'h0, 2'd1); cyc(); idle();
        op_done = 1'b1; cyc(); idle();
        chk(11, {15'h0, irq}, 16'h1, "mask cleared by io_rst");

        // R12 full reset clears registers
        rst = 1'b1; cyc(); rst = 1'b0;
        op(6'd12, 2'd1, 1'b0, 16'h0, 2'd0); #1;
        chk(12, bus_rdata, 16'h0, "A cleared by rst");
        chk(12, {14'h0, done, irq}, 16'h0, "done/irq cleared by rst");
        idle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule